// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a multi-lane on-chip scratchpad. It takes one access per lane from a wave of up to `LANES` lanes. Each lane has a valid bit, a write enable, a byte address and write data. Each 32-bit word address falls into one of `BANKS` banks, chosen by taking the word address modulo the bank count. Every bank moves one word per clock. If the active lanes all fall in different banks, the whole wave is served in one pass. Lanes that share a bank are served over successive passes, and the rest of the wave waits until the last pass ends.

In every pass, each bank serves the lowest-numbered lane that is still pending on it, and that lane then leaves the pending mask. When the mask is empty, the block raises `done` for one cycle. At the same time it shows in `cycles` how many passes the access needed, which is the serialization factor of the wave. Read data is returned per lane. The storage is never cleared, so a cell that has not been written returns whatever it held before. The bank count is a parameter: 32 by default, and 16 is also supported. Any power of two works.

Top module: `banked_scratchpad`

## Requirements
- R1: Bits [1:0] of a lane's byte address are ignored. The word address is the byte address shifted right by 2. The bank is the word address modulo `BANKS`, and the row inside the bank is the word address divided by `BANKS`. A write followed by a read at the same word returns the written data.
- R2: In every pass, each bank serves at most one lane.
- R3: If all valid lanes fall in distinct banks, `cycles` reads 1.
- R4: `cycles` equals the largest number of valid lanes that fall in any one bank. For a constant word stride S over 32 lanes and 32 banks, this is gcd(S, 32).
- R5: Lanes that share a bank are served in ascending lane order. A read in a higher lane sees a write made by a lower lane to the same word in the same request. A read in a lower lane sees the value from before that write.
- R6: A lane whose `lane_valid` bit is 0 writes nothing and is not counted in `cycles`. Its `rd_data` slice keeps its previous value. A valid write lane also keeps its previous `rd_data` slice.
- R7: `req_ready` is high only while idle. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is low from that edge until `done` rises. `done` rises max(`cycles`,1) clock edges after the accepting edge.
- R8: A request with no valid lanes completes with `done` one edge after it is accepted, with `cycles` equal to 0.
- R9: After reset, `req_ready` is 1, `done` is 0, `cycles` is 0 and every `rd_data` slice is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| lane_valid | input | LANES | Per-lane active bit |
| lane_we | input | LANES | Per-lane write enable (1 = write, 0 = read) |
| lane_addr | input | LANES*(log2(BANKS*DEPTH)+2) | Per-lane byte address, lane i at slice i |
| lane_wdata | input | LANES*32 | Per-lane write word |
| rd_data | output | LANES*32 | Per-lane read word, updated for read lanes |
| done | output | 1 | One-cycle completion strobe |
| cycles | output | log2(LANES+1) | Passes used by the last request |

## Verification
On every cycle, the assertions check the following:
- each bank has at most one granted lane;
- grants only go to pending lanes;
- a busy block with pending lanes always makes progress, and the pending set shrinks on each pass;
- `cycles` never exceeds the lane count;
- the handshake moves the block to busy and raises `done` only when ready.

Only the bench scenarios can show the rest, by comparing against a reference model of per-bank lane ranks:
- the exact pass count for strided, sparse and random waves;
- lane-order visibility between writes and reads to the same word;
- that inactive and writing lanes keep their read slices;
- the completion latency.

// File: rtl/bsp_pkg.sv
// Package: shared constants and types for the banked scratchpad.
// Assumes a 32-bit data word throughout.
package bsp_pkg;
    localparam int WORD_W = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } bsp_state_e;
endpackage

// File: rtl/bsp_arbiter.sv
// Module: per-pass bank arbiter.
// For every bank, grants the lowest-numbered pending lane whose bank index
// matches, and gives a per-bank one-hot select of the granted lane.
// Assumes lane_bank is stable for the whole access.
module bsp_arbiter #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int BW    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              pend,
    input  logic [LANES-1:0][BW-1:0]      lane_bank,
    output logic [LANES-1:0]              grant,
    output logic [BANKS-1:0][LANES-1:0]   bank_sel
);
    genvar gi, gb;

    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            // Grant a lane when no lower pending lane shares its bank.
            always_comb begin
                logic blocked;
                blocked = 1'b0;
                for (int j = 0; j < gi; j++) begin
                    if (pend[j] && (lane_bank[j] == lane_bank[gi])) blocked = 1'b1;
                end
                grant[gi] = pend[gi] && !blocked;
            end
        end

        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            // Route each granted lane to the bank it maps onto.
            always_comb begin
                for (int i = 0; i < LANES; i++) begin
                    bank_sel[gb][i] = grant[i] && (lane_bank[i] == BW'(gb));
                end
            end

            AST_ONE_LANE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bank_sel[gb])); // R2
        end
    endgenerate

    AST_GRANT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R6

    AST_PENDING_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> (|grant)); // R5
endmodule

// File: rtl/bsp_bank.sv
// Module: one storage bank serving a single word per clock.
// The lane picked by a one-hot select reads asynchronously or writes on the
// clock edge. Assumes sel is one-hot or zero. Contents are not initialised.
module bsp_bank #(
    parameter int LANES = 32,
    parameter int DEPTH = 16,
    parameter int RW    = 4
) (
    input  logic                                clk,
    input  logic [LANES-1:0]                    sel,
    input  logic [LANES-1:0]                    we,
    input  logic [LANES-1:0][RW-1:0]            row,
    input  logic [LANES-1:0][bsp_pkg::WORD_W-1:0] wdata,
    output logic [bsp_pkg::WORD_W-1:0]          rdata
);
    import bsp_pkg::*;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [RW-1:0]     s_row;
    logic              s_we;
    logic [WORD_W-1:0] s_wd;

    // Fold the selected lane's row, write enable and data onto one port.
    always_comb begin
        s_row = '0;
        s_we  = 1'b0;
        s_wd  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) begin
                s_row = s_row | row[i];
                s_we  = s_we | we[i];
                s_wd  = s_wd | wdata[i];
            end
        end
    end

    // Write the selected word; storage has no reset by intent.
    always_ff @(posedge clk) begin
        if (s_we) mem[s_row] <= s_wd;
    end

    assign rdata = mem[s_row];
endmodule

// File: rtl/banked_scratchpad.sv
// Module: top of the banked scratchpad.
// Latches a wave-wide request, then runs conflict-free passes until every
// valid lane has been served, and gives per-lane read data, a done strobe and
// the pass count. Assumes BANKS and DEPTH are powers of two, DEPTH >= 2.
module banked_scratchpad #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int DEPTH = 16,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(DEPTH),
    localparam int AW   = BW + RW + 2,
    localparam int CW   = $clog2(LANES + 1),
    localparam int DW   = bsp_pkg::WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LANES-1:0]      lane_valid,
    input  logic [LANES-1:0]      lane_we,
    input  logic [LANES*AW-1:0]   lane_addr,
    input  logic [LANES*DW-1:0]   lane_wdata,
    output logic [LANES*DW-1:0]   rd_data,
    output logic                  done,
    output logic [CW-1:0]         cycles
);
    import bsp_pkg::*;

    bsp_state_e                       state;
    logic [LANES-1:0]                 pend;
    logic [LANES-1:0]                 we_q;
    logic [LANES-1:0][AW-1:0]         addr_q;
    logic [LANES-1:0][DW-1:0]         wd_q;
    logic [LANES-1:0][DW-1:0]         rd_q;
    logic [LANES-1:0][BW-1:0]         lane_bank;
    logic [LANES-1:0][RW-1:0]         lane_row;
    logic [LANES-1:0]                 grant;
    logic [BANKS-1:0][LANES-1:0]      bank_sel;
    logic [BANKS-1:0][DW-1:0]         bank_rd;
    logic [LANES-1:0]                 remain;
    logic                             done_q;
    logic [CW-1:0]                    cnt_q;

    genvar gi, gb;

    generate
        for (gi = 0; gi < LANES; gi++) begin : g_split
            // Split each latched byte address into bank and row fields.
            always_comb begin
                lane_bank[gi] = addr_q[gi][BW+1:2];
                lane_row[gi]  = addr_q[gi][AW-1:BW+2];
            end
        end
    endgenerate

    bsp_arbiter #(.LANES(LANES), .BANKS(BANKS), .BW(BW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .lane_bank (lane_bank),
        .grant     (grant),
        .bank_sel  (bank_sel)
    );

    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            bsp_bank #(.LANES(LANES), .DEPTH(DEPTH), .RW(RW)) u_bank (
                .clk   (clk),
                .sel   (bank_sel[gb]),
                .we    (we_q),
                .row   (lane_row),
                .wdata (wd_q),
                .rdata (bank_rd[gb])
            );
        end
    endgenerate

    assign remain = pend & ~grant;

    // Sequence the access: accept, run passes, count them, strobe done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= '0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pend  <= lane_valid;
                        cnt_q <= '0;
                        state <= ST_BUSY;
                    end
                end
                default: begin
                    pend <= remain;
                    if (|grant) cnt_q <= cnt_q + CW'(1);
                    if (remain == '0) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Hold the request operands for the whole access.
    always_ff @(posedge clk) begin
        if (state == ST_IDLE && req_valid) begin
            we_q   <= lane_we;
            addr_q <= lane_addr;
            wd_q   <= lane_wdata;
        end
    end

    // Capture read words for lanes granted a read in this pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (state == ST_BUSY) begin
            for (int i = 0; i < LANES; i++) begin
                if (grant[i] && !we_q[i]) rd_q[i] <= bank_rd[lane_bank[i]];
            end
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = done_q;
    assign cycles    = cnt_q;
    assign rd_data   = rd_q;

    AST_CYCLES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cycles <= CW'(LANES)); // R4

    AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R7

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready); // R7

    AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && (|pend)) |=>
            (state == ST_IDLE || $countones(pend) < $past($countones(pend)))); // R5
endmodule

// File: tb/tb_banked_scratchpad.sv
// Bench: directed corner cases plus seeded random waves, checked against a
// rank-ordered reference model of the scratchpad.
module tb_banked_scratchpad;
    localparam int CLK_P = 10;
    localparam int L     = 32;
    localparam int NB    = 32;
    localparam int D     = 16;
    localparam int AW    = 11;
    localparam int CW    = 6;
    localparam int NW    = NB * D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [L-1:0]      lane_valid = '0;
    logic [L-1:0]      lane_we = '0;
    logic [L*AW-1:0]   lane_addr = '0;
    logic [L*32-1:0]   lane_wdata = '0;
    logic [L*32-1:0]   rd_data;
    logic              done;
    logic [CW-1:0]     cycles;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_mem [NW];
    bit          known [NW];
    bit          s_val [L];
    bit          s_we [L];
    int          s_addr [L];
    logic [31:0] s_wd [L];
    int          seed_dummy;

    always #(CLK_P/2) clk = ~clk;

    banked_scratchpad dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .lane_valid (lane_valid),
        .lane_we    (lane_we),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .rd_data    (rd_data),
        .done       (done),
        .cycles     (cycles)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    task automatic clear_lanes();
        for (int i = 0; i < L; i++) begin
            s_val[i] = 0; s_we[i] = 0; s_addr[i] = 0; s_wd[i] = '0;
        end
    endtask

    // Model the request, drive it, wait for done, compare everything.
    task automatic run_req(input string tag, output int got_cyc);
        int          cnt [NB];
        int          rank [L];
        int          expcyc;
        int          lat;
        logic [31:0] exp_rd [L];
        bit          chk_rd [L];
        logic [31:0] prev_rd [L];
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        expcyc = 0;
        for (int i = 0; i < L; i++) begin
            int bk = (s_addr[i] >> 2) % NB;
            rank[i] = cnt[bk];
            if (s_val[i]) begin
                cnt[bk]++;
                if (cnt[bk] > expcyc) expcyc = cnt[bk];
            end
            chk_rd[i]  = 0;
            exp_rd[i]  = '0;
            prev_rd[i] = rd_data[i*32 +: 32];
        end
        for (int r = 0; r < L; r++) begin
            for (int i = 0; i < L; i++) begin
                if (s_val[i] && rank[i] == r) begin
                    int w = (s_addr[i] >> 2) % NW;
                    if (s_we[i]) begin
                        exp_mem[w] = s_wd[i];
                        known[w]   = 1;
                    end else begin
                        exp_rd[i] = exp_mem[w];
                        chk_rd[i] = known[w];
                    end
                end
            end
        end
        @(negedge clk);
        for (int i = 0; i < L; i++) begin
            lane_valid[i]           = s_val[i];
            lane_we[i]              = s_we[i];
            lane_addr[i*AW +: AW]   = AW'(s_addr[i]);
            lane_wdata[i*32 +: 32]  = s_wd[i];
        end
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R7 ready while idle", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R7 busy after accept", req_ready, 0);
        lat = 0;
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (done) break;
            if (lat > 80) begin
                chk(0, "R7 done never rose", lat, expcyc);
                break;
            end
        end
        chk(lat == ((expcyc > 0) ? expcyc : 1), {"R7 latency ", tag}, lat, expcyc);
        chk(cycles == CW'(expcyc), {tag, " cycles"}, cycles, expcyc);
        got_cyc = int'(cycles);
        for (int i = 0; i < L; i++) begin
            if (s_val[i] && !s_we[i]) begin
                if (chk_rd[i])
                    chk(rd_data[i*32 +: 32] == exp_rd[i], {tag, " R1 read data"},
                        rd_data[i*32 +: 32], exp_rd[i]);
            end else begin
                chk(rd_data[i*32 +: 32] == prev_rd[i], "R6 read slice held",
                    rd_data[i*32 +: 32], prev_rd[i]);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        chk(0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c;
        seed_dummy = $urandom(32'h5CA7_C0DE);
        for (int w = 0; w < NW; w++) begin known[w] = 0; exp_mem[w] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
        chk(done == 1'b0, "R9 done after reset", done, 0);
        chk(cycles == '0, "R9 cycles after reset", cycles, 0);
        chk(rd_data == '0, "R9 rd_data after reset", 0, 0);

        // R3: fill every word, all lanes distinct banks, one pass each
        for (int k = 0; k < D; k++) begin
            clear_lanes();
            for (int i = 0; i < L; i++) begin
                s_val[i] = 1; s_we[i] = 1;
                s_addr[i] = ((k * NB + i) << 2) | int'($urandom_range(0, 3));
                s_wd[i] = $urandom;
            end
            run_req("R3 fill", c);
        end

        // R1: read back one row with junk in byte offset bits
        clear_lanes();
        for (int i = 0; i < L; i++) begin
            s_val[i] = 1; s_addr[i] = ((3 * NB + i) << 2) | 3;
        end
        run_req("R3 readback", c);

        // R4: constant strides give gcd(S,32) passes
        for (int si = 0; si < 6; si++) begin
            int s = 1 << si;
            clear_lanes();
            for (int i = 0; i < L; i++) begin
                s_val[i] = 1; s_addr[i] = ((i * s) % NW) << 2;
            end
            run_req("R4 stride", c);
            chk(c == gcd(s, 32), "R4 stride gcd", c, gcd(s, 32));
        end
        clear_lanes();
        for (int i = 0; i < L; i++) begin
            s_val[i] = 1; s_addr[i] = ((i * 3) % NW) << 2;
        end
        run_req("R4 stride3", c);
        chk(c == 1, "R4 odd stride one pass", c, 1);

        // R8: no valid lanes
        clear_lanes();
        for (int i = 0; i < L; i++) begin s_we[i] = 1; s_addr[i] = 0; s_wd[i] = 32'hDEAD; end
        run_req("R8 empty", c);
        chk(c == 0, "R8 zero passes", c, 0);

        // R6: only two valid lanes in bank 0, invalid lanes also in bank 0
        clear_lanes();
        for (int i = 0; i < L; i++) begin
            s_we[i] = (i % 2 == 1); s_addr[i] = (i * NB % NW) << 2; s_wd[i] = 32'hBAD0_0000 + i;
        end
        s_val[4] = 1; s_val[12] = 1;
        run_req("R6 sparse", c);
        chk(c == 2, "R6 invalid lanes not counted", c, 2);
        clear_lanes();
        for (int i = 0; i < L; i++) begin s_val[i] = 1; s_addr[i] = (i * NB % NW) << 2; end
        run_req("R6 invalid writes absent", c);

        // R5: lane order inside one bank
        clear_lanes();
        s_val[1] = 1; s_addr[1] = 70 << 2;
        s_val[3] = 1; s_we[3] = 1; s_addr[3] = 70 << 2; s_wd[3] = 32'h1234_5678;
        s_val[9] = 1; s_addr[9] = 70 << 2;
        s_val[20] = 1; s_we[20] = 1; s_addr[20] = 70 << 2; s_wd[20] = 32'hCAFE_F00D;
        s_val[25] = 1; s_addr[25] = 102 << 2;
        run_req("R5 order", c);
        chk(rd_data[9*32 +: 32] == 32'h1234_5678, "R5 higher lane sees lower write",
            rd_data[9*32 +: 32], 32'h1234_5678);

        // R2: random waves
        for (int n = 0; n < 400; n++) begin
            int span = (n % 4 == 0) ? NW : 64;
            clear_lanes();
            for (int i = 0; i < L; i++) begin
                s_val[i]  = ($urandom_range(0, 3) != 0);
                s_we[i]   = ($urandom_range(0, 2) == 0);
                s_addr[i] = int'($urandom_range(0, span - 1)) * 4 + int'($urandom_range(0, 3));
                s_wd[i]   = $urandom;
            end
            run_req("R2 random", c);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule